// File: doc/BRIEF.md
# DMA Channel Trigger Sequencer

This block decides, cycle by cycle, when a single DMA channel may issue its next data transfer. Software sets up the channel's trigger configuration and a total transfer count, then pulses a start input. From that point the block raises a transfer request that the transfer engine accepts once per transfer. The block counts accepted transfers and raises a done flag when the total has been reached.

The pacing of requests depends on the configuration. With hardware triggering off, the channel runs freely until the count is used up. With hardware triggering on, a synchronized trigger line paces the channel. In edge mode, each qualifying edge releases either one transfer or a burst of 2^N transfers. In level mode, bursts are released for as long as the trigger stays at its active level. A peripheral request line can also gate every request, or it can be ignored completely for memory-to-memory moves.

The transfer request is a valid/ready stream with no payload. A transfer happens on each clock edge where `req_valid` and `req_ready` are both high. Once `req_valid` is raised, it stays high until it is accepted. The one exception is the peripheral gate: when peripheral gating is enabled and `periph_req` falls, the request is withdrawn. All configuration inputs must stay constant while `busy` is high.

Top module: `dma_trig_seq`

## Requirements
- R1: A `sw_start` pulse is accepted only when all of these hold: `busy` is low, `cfg_err` is low and `xfer_total` is nonzero. An accepted start sets `busy` and clears `done` on the next cycle. After exactly `xfer_total` accepted transfers, `busy` falls and `done` rises together. `done` and `busy` are never high at the same time.
- R2: When `cfg_preq_en`=1, `req_valid` is high only while `periph_req`=1. When `cfg_preq_en`=0, `periph_req` has no effect.
- R3: When `cfg_hw_en`=0, requests are issued back to back. With `req_ready` held high, `busy` stays high for exactly `xfer_total` cycles.
- R4: `cfg_pol`=1 selects active-high level or rising edge. `cfg_pol`=0 selects active-low level or falling edge. The trigger passes through a two-stage synchronizer before the polarity is applied.
- R5: In edge mode (`cfg_level`=0) with `cfg_burst`=0, each qualifying edge releases exactly one transfer.
- R6: In edge mode with `cfg_burst`=1, each qualifying edge releases 2^`cfg_bexp` transfers.
- R7: An edge that arrives while a burst is still in progress is held as one pending start, which runs when that burst finishes. Further edges that arrive while a start is already pending are dropped.
- R8: In level mode (`cfg_level`=1), bursts are released while the trigger is active. When the trigger goes inactive, issuing pauses only after the current burst has completed. Issuing resumes when the trigger becomes active again.
- R9: Once the total count is reached, no further request is issued, even if a level trigger is still active.
- R10: `cfg_err` is high exactly when `cfg_bexp` is greater than 10. While `cfg_err` is high, a start is refused. The value 10 is legal and gives a burst of 1024.
- R11: After reset, `req_valid`, `busy`, `done` and `cfg_err` are all low when the reset configuration is all zeros.
- R12: If `req_valid` is high and `req_ready` is low, `req_valid` is still high on the next cycle, unless the peripheral gate closes.
- R13: Trigger edges that occur while the channel is idle are not remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_start | input | 1 | One-cycle software start pulse |
| hw_trig | input | 1 | Raw asynchronous hardware trigger |
| periph_req | input | 1 | Peripheral request gate |
| cfg_preq_en | input | 1 | Enable peripheral gating |
| cfg_hw_en | input | 1 | Enable hardware trigger pacing |
| cfg_pol | input | 1 | Trigger polarity, 1 = high or rising |
| cfg_level | input | 1 | Trigger type, 1 = level, 0 = edge |
| cfg_burst | input | 1 | 1 = burst per trigger, 0 = single |
| cfg_bexp | input | 4 | Burst size exponent, legal range 0..10 |
| xfer_total | input | CNT_W | Total transfers for one start |
| req_valid | output | 1 | Transfer request |
| req_ready | input | 1 | Transfer acceptance |
| busy | output | 1 | Channel active |
| done | output | 1 | Total count reached |
| cfg_err | output | 1 | Unsupported burst exponent |

## Verification
The assertions check on every cycle the rules that concern a single cycle or the step to the next one. These are the silence of the request while idle, the peripheral gate, the holding of an unaccepted request, the refusal of a start under a bad exponent, and the start and done handshake. How many transfers a pattern of edges or levels releases can only be shown by the bench's scenarios. The same holds for burst completion before a level pause, the collapse of extra edges into a single pending start, and the stop at the total count under a still-active trigger. For these, the bench counts accepted transfers and compares them with expected counts it computes.

// File: rtl/dts_pkg.sv
package dts_pkg;

  typedef enum logic {
    POL_LOW  = 1'b0,
    POL_HIGH = 1'b1
  } trig_pol_e;

  typedef enum logic {
    MODE_EDGE  = 1'b0,
    MODE_LEVEL = 1'b1
  } trig_mode_e;

  localparam int EXP_BITS = 4;

endpackage

// File: rtl/dts_trig_front.sv
// Synchronizes the raw trigger, applies polarity and flags qualifying edges.
module dts_trig_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic pol,
  output logic act,
  output logic rise_o
);
  import dts_pkg::*;

  logic synced;
  logic act_q;

  generate
    if (STAGES == 1) begin : g_one
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= 1'b0;
        else        s_q <= raw;
      end
      assign synced = s_q;
    end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], raw};
      end
      assign synced = sh_q[STAGES-1];
    end
  endgenerate

  assign act = (pol == POL_HIGH) ? synced : ~synced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act;
  end

  assign rise_o = act & ~act_q;

endmodule

// File: rtl/dts_count.sv
// Tracks the remaining transfers of one start and the busy/done flags.
module dts_count #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_ok,
  input  logic             fire,
  input  logic [CNT_W-1:0] total,
  output logic             busy,
  output logic             done,
  output logic             ending
);
  logic [CNT_W-1:0] rem_q;

  assign ending = fire && (rem_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else if (start_ok) begin
      rem_q <= total;
      busy  <= 1'b1;
      done  <= 1'b0;
    end else if (fire) begin
      rem_q <= rem_q - CNT_W'(1);
      if (ending) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dts_burst.sv
// Holds the credit of the running burst and a single pending edge start.
module dts_burst #(
  parameter int BL_W = 11
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      busy,
  input  logic                      ending,
  input  logic                      hw_en,
  input  logic                      level,
  input  logic                      burst,
  input  logic [dts_pkg::EXP_BITS-1:0] bexp,
  input  logic                      act,
  input  logic                      rise,
  input  logic                      fire,
  output logic                      have
);
  import dts_pkg::*;

  logic [BL_W-1:0] left_q, left_dec, size;
  logic            pend_q;

  assign size     = burst ? (BL_W'(1) << bexp) : BL_W'(1);
  assign left_dec = (fire && left_q != '0) ? left_q - BL_W'(1) : left_q;
  assign have     = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      pend_q <= 1'b0;
    end else if (!busy || ending || !hw_en) begin
      left_q <= '0;
      pend_q <= 1'b0;
    end else if (level == MODE_LEVEL) begin
      pend_q <= 1'b0;
      if (left_dec == '0 && act) left_q <= size;
      else                       left_q <= left_dec;
    end else if (left_dec == '0) begin
      if (pend_q) begin
        left_q <= size;
        pend_q <= rise;
      end else if (rise) begin
        left_q <= size;
      end else begin
        left_q <= left_dec;
      end
    end else begin
      left_q <= left_dec;
      if (rise) pend_q <= 1'b1;
    end
  end

endmodule

// File: rtl/dma_trig_seq.sv
// Decides when one DMA channel may issue a transfer.
module dma_trig_seq #(
  parameter int CNT_W     = 11,
  parameter int BEXP_MAX  = 10,
  parameter int SYNC_STGS = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sw_start,
  input  logic                          hw_trig,
  input  logic                          periph_req,
  input  logic                          cfg_preq_en,
  input  logic                          cfg_hw_en,
  input  logic                          cfg_pol,
  input  logic                          cfg_level,
  input  logic                          cfg_burst,
  input  logic [dts_pkg::EXP_BITS-1:0]  cfg_bexp,
  input  logic [CNT_W-1:0]              xfer_total,
  output logic                          req_valid,
  input  logic                          req_ready,
  output logic                          busy,
  output logic                          done,
  output logic                          cfg_err
);
  import dts_pkg::*;

  localparam int                BL_W    = BEXP_MAX + 1;
  localparam logic [EXP_BITS-1:0] EXP_LIM = EXP_BITS'(BEXP_MAX);

  logic act, rise, have, ending, fire, gate, start_ok;

  assign cfg_err  = (cfg_bexp > EXP_LIM);
  assign start_ok = sw_start && !busy && !cfg_err && (xfer_total != '0);
  assign gate     = !cfg_preq_en || periph_req;
  assign req_valid = busy && gate && (cfg_hw_en ? have : 1'b1);
  assign fire     = req_valid && req_ready;

  dts_trig_front #(.STAGES(SYNC_STGS)) u_front (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw    (hw_trig),
    .pol    (cfg_pol),
    .act    (act),
    .rise_o (rise)
  );

  dts_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_ok (start_ok),
    .fire     (fire),
    .total    (xfer_total),
    .busy     (busy),
    .done     (done),
    .ending   (ending)
  );

  dts_burst #(.BL_W(BL_W)) u_burst (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .ending (ending),
    .hw_en  (cfg_hw_en),
    .level  (cfg_level),
    .burst  (cfg_burst),
    .bexp   (cfg_bexp),
    .act    (act),
    .rise   (rise),
    .fire   (fire),
    .have   (have)
  );

endmodule

// File: rtl/dts_checker.sv
module dts_checker #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_start,
  input logic             periph_req,
  input logic             cfg_preq_en,
  input logic [CNT_W-1:0] xfer_total,
  input logic             req_valid,
  input logic             req_ready,
  input logic             busy,
  input logic             done,
  input logic             cfg_err
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid); // R1

  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy)); // R1

  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    sw_start && !busy && !cfg_err && (xfer_total != '0) |=> busy && !done); // R1

  AST_PREQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_preq_en && !periph_req |-> !req_valid); // R2

  AST_BAD_CFG_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err && !busy |=> !busy); // R10

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid || (cfg_preq_en && !periph_req)); // R12

endmodule

bind dma_trig_seq dts_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sw_start    (sw_start),
  .periph_req  (periph_req),
  .cfg_preq_en (cfg_preq_en),
  .xfer_total  (xfer_total),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .busy        (busy),
  .done        (done),
  .cfg_err     (cfg_err)
);

// File: tb/dma_trig_seq_test.sv
`timescale 1ns/100ps
module dma_trig_seq_test;
  localparam int CNT_W = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_start = 0, hw_trig = 0, periph_req = 0;
  logic cfg_preq_en = 0, cfg_hw_en = 0, cfg_pol = 0, cfg_level = 0, cfg_burst = 0;
  logic [3:0] cfg_bexp = 0;
  logic [CNT_W-1:0] xfer_total = 0;
  logic req_ready = 0;
  logic req_valid, busy, done, cfg_err;

  int checks = 0, errors = 0, fires = 0, rdy_pct = 100;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_trig_seq #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .hw_trig(hw_trig),
    .periph_req(periph_req), .cfg_preq_en(cfg_preq_en), .cfg_hw_en(cfg_hw_en),
    .cfg_pol(cfg_pol), .cfg_level(cfg_level), .cfg_burst(cfg_burst),
    .cfg_bexp(cfg_bexp), .xfer_total(xfer_total), .req_valid(req_valid),
    .req_ready(req_ready), .busy(busy), .done(done), .cfg_err(cfg_err)
  );

  always @(posedge clk) begin
    #1;
    req_ready = (($urandom % 100) < rdy_pct);
  end

  always @(negedge clk)
    if (rst_n && req_valid && req_ready) fires++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 0;
    cyc(3);
    rst_n = 1;
    cyc(2);
    fires = 0;
  endtask

  task automatic start();
    sw_start = 1;
    cyc(1);
    sw_start = 0;
  endtask

  task automatic pulse(input int hi, input int lo);
    hw_trig = cfg_pol;
    cyc(hi);
    hw_trig = ~cfg_pol;
    cyc(lo);
  endtask

  task automatic wait_fires(input int target, input int maxc);
    for (int i = 0; i < maxc && fires < target; i++) cyc(1);
  endtask

  function automatic int exp_edge(input int edges, input int bexp, input bit burst, input int total);
    int n;
    n = edges * (burst ? (1 << bexp) : 1);
    return (n > total) ? total : n;
  endfunction

  task automatic setup(input bit hw, input bit pol, input bit lvl, input bit bst,
                       input int bexp, input int total);
    cfg_hw_en = hw; cfg_pol = pol; cfg_level = lvl; cfg_burst = bst;
    cfg_bexp = 4'(bexp); xfer_total = CNT_W'(total);
    hw_trig = ~pol;
    do_reset();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int f1, tot, bx, edges, ex;
    bit bs;
    void'($urandom(32'h5EED_0042));
    do_reset();
    @(negedge clk);
    chk(!req_valid && !busy && !done && !cfg_err, "R11 reset state", busy, 0);
    cyc(1);

    // R1: zero total refused
    setup(0, 1, 0, 0, 0, 0);
    start(); cyc(3);
    chk(busy == 0, "R1 zero total refused", busy, 0);

    // R3: back-to-back busy window
    setup(0, 1, 0, 0, 0, 17);
    rdy_pct = 100;
    begin
      int bcyc = 0;
      start();
      for (int i = 0; i < 40; i++) begin @(negedge clk); if (busy) bcyc++; end
      cyc(1);
      chk(bcyc == 17, "R3 busy cycles", bcyc, 17);
      chk(fires == 17 && done, "R1 count and done", fires, 17);
    end

    // R1/R3 random free-run
    for (int it = 0; it < 3; it++) begin
      tot = 1 + $urandom % 40;
      setup(0, 1, 0, 0, 0, tot);
      rdy_pct = 60;
      start(); wait_fires(tot, 2000); cyc(4);
      chk(fires == tot && done && !busy, "R1 random total", fires, tot);
    end

    // R2: peripheral gate
    setup(0, 1, 0, 0, 0, 6);
    rdy_pct = 100; cfg_preq_en = 1; periph_req = 0;
    start(); cyc(20);
    chk(fires == 0 && busy, "R2 gate closed", fires, 0);
    periph_req = 1; cyc(12);
    chk(fires == 6 && done, "R2 gate open", fires, 6);
    cfg_preq_en = 0; periph_req = 0;
    setup(0, 1, 0, 0, 0, 5);
    start(); cyc(12);
    chk(fires == 5 && done, "R2 request ignored when disabled", fires, 5);

    // R13: idle edges forgotten
    setup(1, 1, 0, 0, 0, 4);
    pulse(3, 3); pulse(3, 3);
    start(); cyc(20);
    chk(fires == 0 && busy, "R13 idle edges", fires, 0);

    // R5/R4: rising edges, single
    setup(1, 1, 0, 0, 0, 8);
    start();
    for (int i = 0; i < 3; i++) pulse(4, 8);
    cyc(10);
    chk(fires == 3 && busy, "R5 one per rising edge", fires, 3);

    // R4: falling edges with polarity 0
    setup(1, 0, 0, 0, 0, 8);
    start(); cyc(5);
    pulse(4, 8); pulse(4, 8); cyc(10);
    chk(fires == 2, "R4 falling edges", fires, 2);

    // R6: burst per edge
    setup(1, 1, 0, 1, 2, 12);
    start();
    pulse(3, 20); pulse(3, 20);
    chk(fires == 8, "R6 burst of four", fires, 8);
    pulse(3, 20);
    chk(fires == 12 && done, "R6 final burst", fires, 12);

    // R7/R12: pending start collapses extra edges
    setup(1, 1, 0, 1, 3, 32);
    rdy_pct = 0; cyc(2);
    start();
    for (int i = 0; i < 4; i++) pulse(3, 3);
    cyc(10);
    chk(req_valid == 1 && fires == 0, "R12 request held", req_valid, 1);
    rdy_pct = 100; cyc(60);
    chk(fires == 16 && busy, "R7 one pending start", fires, 16);

    // R8/R9: level with bursts
    setup(1, 1, 1, 1, 2, 40);
    rdy_pct = 100;
    start();
    hw_trig = 1; cyc(7); hw_trig = 0; cyc(20);
    chk(fires > 0 && fires % 4 == 0 && busy, "R8 pause at burst end", fires, 4 * (fires / 4));
    rdy_pct = 30;
    hw_trig = 1; cyc(5); hw_trig = 0; cyc(80);
    chk(fires % 4 == 0, "R8 burst completes under stall", fires, 4 * (fires / 4));
    f1 = fires; cyc(15);
    chk(fires == f1, "R8 paused", fires, f1);
    rdy_pct = 100;
    hw_trig = 1; wait_fires(40, 2000); cyc(12);
    chk(fires == 40 && !busy && done && !req_valid, "R9 stop at total", fires, 40);
    hw_trig = 0;

    // R8/R4: level, single, active low
    setup(1, 0, 1, 0, 0, 200);
    start();
    hw_trig = 0; cyc(10); hw_trig = 1; cyc(6);
    f1 = fires; cyc(12);
    chk(f1 > 0 && fires == f1, "R8 active-low level pause", fires, f1);

    // R10: exponent limits
    setup(1, 1, 0, 1, 11, 16);
    @(negedge clk);
    chk(cfg_err == 1, "R10 flag on 11", cfg_err, 1);
    cyc(1); start(); cyc(5);
    chk(busy == 0 && fires == 0, "R10 start refused", busy, 0);
    setup(1, 1, 0, 1, 10, 1024);
    rdy_pct = 100;
    @(negedge clk);
    chk(cfg_err == 0, "R10 ten is legal", cfg_err, 0);
    cyc(1); start(); pulse(3, 3);
    wait_fires(1024, 1500); cyc(4);
    chk(fires == 1024 && done, "R6 burst of 1024", fires, 1024);

    // R5/R6 random edge runs
    for (int it = 0; it < 6; it++) begin
      bx = $urandom % 4; bs = 1'($urandom % 2);
      tot = (bs ? (1 << bx) : 1) * (1 + $urandom % 4);
      edges = 1 + $urandom % 5;
      setup(1, 1'($urandom % 2), 0, bs, bx, tot);
      rdy_pct = 50;
      start(); cyc(3);
      for (int k = 1; k <= edges; k++) begin
        pulse(3, 3);
        wait_fires(exp_edge(k, bx, bs, tot), 3000);
      end
      cyc(20);
      ex = exp_edge(edges, bx, bs, tot);
      chk(fires == ex && busy == (ex < tot) && done == (ex == tot), "R6 random edges", fires, ex);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule